// File: doc/BRIEF.md
# Host Register Port with CAM Arbitration

This block is the processor-facing side of an address-filtering engine that sits beside a content-addressable memory (CAM). A host reaches it over a synchronous 16-bit slave bus with active-low select, strobe and write-enable inputs, a 4-bit address and a data bus. The data bus is modelled as an output value plus an output enable. The block holds the engine's configuration and result registers. It also forwards host command and data cycles to the CAM, and on a write to the stamp register it issues a one-cycle start pulse for an aging purge.

The CAM is shared with the network sequencer, and the network always wins. A host CAM cycle that arrives while the network is using the CAM is held pending. It is granted at the first clock edge that samples the network busy flag low. From that grant, the READY handshake follows a fixed latency for each access type.

Top module: `hreg_cam_port`

## Requirements
- R1: Register map by address: 0 control (reset 0000h), 1 status (read only), 2 learn opcode (reset 0334h), 3 associated data (read only), 8 update opcode (reset 0300h), 9 purge opcode (reset 043Dh), A time stamp (reset 0000h). Writes to 1 and 3 leave those registers unchanged, and the writable registers read back what was written.
- R2: An access starts at the first rising clock edge that samples both `cs_n` and `as_n` low. The address is latched at the edge where `as_n` is first sampled low, so later changes to `addr` do not redirect that access. A low strobe alone starts nothing.
- R3: For a local register write, `ready` is low after the start edge and high again after the next edge. The data is captured at that second edge.
- R4: For a local register read, `ready` stays high. Read data is on `d_out` with `d_oe` high after the second edge.
- R5: Addresses 4 and 5 are CAM command cycles, and 6 and 7 are CAM data cycles. An even address drives `hcam_ec_low` high and an odd address drives it low. After the grant, `ready` returns high 3 edges later for a write and 5 edges later for a read. A read returns the `cam_rdata` value sampled at that last edge. `hcam_go` pulses once, after the grant edge, carrying the cycle attributes and the write data.
- R6: `hcam_go` is never issued after an edge that sampled `net_busy` high. A pending host CAM cycle is granted at the first edge that samples `net_busy` low, and `ready` stays low for the whole wait.
- R7: `stat_load` ORs `stat_bits` into status and drives `int_n` low. A completed read of address 1 returns the status, clears it and returns `int_n` high. If `stat_load` arrives on the clearing edge, the new bits are kept and `int_n` stays low.
- R8: Writing address A gives a one-cycle `purge_go` pulse after the capture edge. `purge_old_ts` carries the low byte written and `new_ts` the high byte.
- R9: `d_oe` is low whenever `cs_n` is high and whenever no read is being returned.
- R10: `assoc_load` stores `assoc_data` into the associated data register, which is readable at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| as_n | input | 1 | Host address strobe, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 4 | Host register address |
| d_in | input | 16 | Host write data |
| d_out | output | 16 | Host read data |
| d_oe | output | 1 | Drive enable for the host data bus |
| ready | output | 1 | Access handshake, low while busy |
| int_n | output | 1 | Interrupt, active low |
| net_busy | input | 1 | Network sequencer owns the CAM |
| stat_load | input | 1 | Network result strobe |
| stat_bits | input | 8 | Result bits ORed into status |
| assoc_load | input | 1 | Associated data strobe |
| assoc_data | input | 16 | Associated data from the CAM |
| cam_rdata | input | 16 | CAM read data for host cycles |
| hcam_go | output | 1 | Host CAM cycle granted (one cycle) |
| hcam_busy | output | 1 | Host owns the CAM |
| hcam_cmd | output | 1 | 1 = command cycle, 0 = data cycle |
| hcam_write | output | 1 | 1 = host CAM write |
| hcam_ec_low | output | 1 | Daisy-chain enable driven low |
| hcam_wdata | output | 16 | Host CAM write data |
| ctrl_q | output | 16 | Control register |
| learn_op | output | 16 | Learn opcode |
| update_op | output | 16 | Update opcode |
| purge_op | output | 16 | Purge opcode |
| purge_go | output | 1 | Purge start pulse |
| purge_old_ts | output | 8 | Stamp to purge |
| new_ts | output | 8 | Stamp for later updates |

## Verification
The status read and a fresh network result can land on the same clock edge. In that case the clear and the set compete for both the status register and `int_n`. The bench provokes this by raising `stat_load` between the start edge and the capture edge of a status read. It then expects the read to return the old contents, `int_n` to stay low, and a second read to return only the new bits. A second overlap is a host CAM request made while `net_busy` is high. The bench holds the network busy for several edges and checks that no grant appears before release and that the READY low time equals the wait plus the fixed latency.

// File: rtl/hr_pkg.sv
package hr_pkg;
   localparam int A_CTRL  = 0;
   localparam int A_STAT  = 1;
   localparam int A_LEARN = 2;
   localparam int A_ASSOC = 3;
   localparam int A_UPD   = 8;
   localparam int A_PURGE = 9;
   localparam int A_TS    = 10;

   typedef enum logic [1:0] {
      S_IDLE,
      S_LOC,
      S_CAM,
      S_HOLD
   } bus_state_e;
endpackage

// File: rtl/hr_decode.sv
module hr_decode #(
   parameter int AW = 4
) (
   input  logic [AW-1:0] a,
   output logic          is_cam,
   output logic          cam_cmd,
   output logic          cam_ec_low
);
   // window 4..7: bit 1 picks data over command, bit 0 picks chain enable high
   assign is_cam     = ((a >> 2) == AW'(1));
   assign cam_cmd    = ~a[1];
   assign cam_ec_low = ~a[0];
endmodule

// File: rtl/hr_regfile.sv
module hr_regfile
   import hr_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 16,
   parameter int SW = 8,
   localparam int TSW = DW / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [AW-1:0]  a,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   input  logic           stat_load,
   input  logic [SW-1:0]  stat_bits,
   input  logic           assoc_load,
   input  logic [DW-1:0]  assoc_data,
   output logic [DW-1:0]  ctrl_q,
   output logic [DW-1:0]  learn_q,
   output logic [DW-1:0]  upd_q,
   output logic [DW-1:0]  purge_q,
   output logic [DW-1:0]  ts_q,
   output logic           purge_go,
   output logic           int_n
);
   logic [SW-1:0] stat_q;
   logic [DW-1:0] assoc_q;
   logic          int_q;
   logic          clr;

   assign clr = rd_en && (a == AW'(A_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         learn_q  <= DW'(16'h0334);
         upd_q    <= DW'(16'h0300);
         purge_q  <= DW'(16'h043D);
         ts_q     <= '0;
         purge_go <= 1'b0;
      end else begin
         purge_go <= 1'b0;
         if (wr_en) begin
            case (int'(a))
               A_CTRL:  ctrl_q  <= wdata;
               A_LEARN: learn_q <= wdata;
               A_UPD:   upd_q   <= wdata;
               A_PURGE: purge_q <= wdata;
               A_TS: begin
                  ts_q     <= wdata;
                  purge_go <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // a fresh network result wins over a clearing read on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         int_q  <= 1'b0;
      end else if (stat_load) begin
         stat_q <= (clr ? '0 : stat_q) | stat_bits;
         int_q  <= 1'b1;
      end else if (clr) begin
         stat_q <= '0;
         int_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          assoc_q <= '0;
      else if (assoc_load) assoc_q <= assoc_data;
   end

   always_comb begin
      case (int'(a))
         A_CTRL:  rdata = ctrl_q;
         A_STAT:  rdata = DW'(stat_q);
         A_LEARN: rdata = learn_q;
         A_ASSOC: rdata = assoc_q;
         A_UPD:   rdata = upd_q;
         A_PURGE: rdata = purge_q;
         A_TS:    rdata = ts_q;
         default: rdata = '0;
      endcase
   end

   assign int_n = ~int_q;

   AST_INT_RISE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_n) |-> $past(clr)); // R7
   AST_PURGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      purge_go |=> !purge_go); // R8
   AST_PURGE_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
      purge_go |-> (ts_q[TSW-1:0] == $past(wdata[TSW-1:0]))); // R8
endmodule

// File: rtl/hr_cam_arb.sv
module hr_cam_arb #(
   parameter int WR_LAT = 3,
   parameter int RD_LAT = 5,
   localparam int MAXL = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT,
   localparam int CW = $clog2(MAXL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_wr,
   input  logic net_busy,
   output logic go,
   output logic busy,
   output logic done
);
   logic          pend_q;
   logic          wr_q;
   logic          wsel;
   logic [CW-1:0] cnt_q;

   assign wsel = start ? is_wr : wr_q;
   assign done = busy && (cnt_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         busy   <= 1'b0;
         go     <= 1'b0;
         wr_q   <= 1'b0;
         cnt_q  <= '0;
      end else begin
         go <= 1'b0;
         if (start) wr_q <= is_wr;
         if (busy) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) busy <= 1'b0;
         end else if ((start || pend_q) && !net_busy) begin
            busy   <= 1'b1;
            go     <= 1'b1;
            pend_q <= 1'b0;
            cnt_q  <= wsel ? CW'(WR_LAT) : CW'(RD_LAT);
         end else if (start) begin
            pend_q <= 1'b1;
         end
      end
   end

   AST_GRANT_NET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !$past(net_busy)); // R6
   AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!busy && !pend_q)); // R5
   AST_PEND_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && net_busy) |=> !go); // R6
endmodule

// File: rtl/hreg_cam_port.sv
module hreg_cam_port
   import hr_pkg::*;
#(
   parameter int  AW = 4,
   parameter int  DW = 16,
   parameter int  SW = 8,
   parameter int  WR_LAT = 3,
   parameter int  RD_LAT = 5,
   parameter bit  LATCH_ON_STROBE = 1'b1,
   localparam int TSW = DW / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           as_n,
   input  logic           we_n,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  d_in,
   output logic [DW-1:0]  d_out,
   output logic           d_oe,
   output logic           ready,
   output logic           int_n,
   input  logic           net_busy,
   input  logic           stat_load,
   input  logic [SW-1:0]  stat_bits,
   input  logic           assoc_load,
   input  logic [DW-1:0]  assoc_data,
   input  logic [DW-1:0]  cam_rdata,
   output logic           hcam_go,
   output logic           hcam_busy,
   output logic           hcam_cmd,
   output logic           hcam_write,
   output logic           hcam_ec_low,
   output logic [DW-1:0]  hcam_wdata,
   output logic [DW-1:0]  ctrl_q,
   output logic [DW-1:0]  learn_op,
   output logic [DW-1:0]  update_op,
   output logic [DW-1:0]  purge_op,
   output logic           purge_go,
   output logic [TSW-1:0] purge_old_ts,
   output logic [TSW-1:0] new_ts
);
   if (DW < 16) begin : g_bad_dw
      $error("hreg_cam_port: DW must be at least 16");
   end
   if (AW < 4) begin : g_bad_aw
      $error("hreg_cam_port: AW must be at least 4");
   end
   if (WR_LAT < 1 || RD_LAT < 1) begin : g_bad_lat
      $error("hreg_cam_port: CAM latencies must be at least 1");
   end

   bus_state_e    st_q;
   logic [AW-1:0] acc_a_q;
   logic [AW-1:0] eff_a;
   logic          wr_q;
   logic          oe_q;
   logic [DW-1:0] dout_q;
   logic          start;
   logic          dec_cam, dec_cmd, dec_ecl;
   logic          arb_done;
   logic [DW-1:0] rf_rdata;
   logic [DW-1:0] ts_q;

   // address capture: at the strobe's falling edge, or at the start edge
   if (LATCH_ON_STROBE) begin : g_strobe_latch
      logic          as_prev_q;
      logic [AW-1:0] alat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            as_prev_q <= 1'b1;
            alat_q    <= '0;
         end else begin
            as_prev_q <= as_n;
            if (!as_n && as_prev_q) alat_q <= addr;
         end
      end
      assign eff_a = (!as_n && as_prev_q) ? addr : alat_q;
   end else begin : g_start_sample
      assign eff_a = addr;
   end

   assign start = (st_q == S_IDLE) && !cs_n && !as_n;

   hr_decode #(.AW(AW)) u_dec (
      .a          (eff_a),
      .is_cam     (dec_cam),
      .cam_cmd    (dec_cmd),
      .cam_ec_low (dec_ecl)
   );

   hr_cam_arb #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start && dec_cam),
      .is_wr    (!we_n),
      .net_busy (net_busy),
      .go       (hcam_go),
      .busy     (hcam_busy),
      .done     (arb_done)
   );

   hr_regfile #(.AW(AW), .DW(DW), .SW(SW)) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      ((st_q == S_LOC) && wr_q),
      .rd_en      ((st_q == S_LOC) && !wr_q),
      .a          (acc_a_q),
      .wdata      (d_in),
      .rdata      (rf_rdata),
      .stat_load  (stat_load),
      .stat_bits  (stat_bits),
      .assoc_load (assoc_load),
      .assoc_data (assoc_data),
      .ctrl_q     (ctrl_q),
      .learn_q    (learn_op),
      .upd_q      (update_op),
      .purge_q    (purge_op),
      .ts_q       (ts_q),
      .purge_go   (purge_go),
      .int_n      (int_n)
   );

   assign purge_old_ts = ts_q[TSW-1:0];
   assign new_ts       = ts_q[DW-1:TSW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         acc_a_q     <= '0;
         wr_q        <= 1'b0;
         ready       <= 1'b1;
         oe_q        <= 1'b0;
         dout_q      <= '0;
         hcam_cmd    <= 1'b0;
         hcam_write  <= 1'b0;
         hcam_ec_low <= 1'b0;
         hcam_wdata  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               acc_a_q <= eff_a;
               wr_q    <= !we_n;
               if (dec_cam) begin
                  ready       <= 1'b0;
                  st_q        <= S_CAM;
                  hcam_cmd    <= dec_cmd;
                  hcam_ec_low <= dec_ecl;
                  hcam_write  <= !we_n;
                  hcam_wdata  <= d_in;
               end else begin
                  if (!we_n) ready <= 1'b0;
                  st_q <= S_LOC;
               end
            end
            S_LOC: begin
               ready <= 1'b1;
               if (!wr_q) begin
                  dout_q <= rf_rdata;
                  oe_q   <= 1'b1;
               end
               st_q <= S_HOLD;
            end
            S_CAM: if (arb_done) begin
               ready <= 1'b1;
               if (!wr_q) begin
                  dout_q <= cam_rdata;
                  oe_q   <= 1'b1;
               end
               st_q <= S_HOLD;
            end
            S_HOLD: if (cs_n || as_n) begin
               oe_q <= 1'b0;
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign d_out = dout_q;
   assign d_oe  = oe_q && !cs_n;

   AST_READ_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> ready); // R4
   AST_LOCAL_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_LOC) |=> ready); // R3
   AST_HOLD_CAM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_HOLD) |-> !hcam_busy); // R5
   AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CAM) |-> !ready); // R6
endmodule

// File: tb/tb_hreg_cam_port.sv
module tb_hreg_cam_port;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_n, as_n, we_n;
   logic [3:0]  addr;
   logic [15:0] d_in, d_out;
   logic        d_oe, ready, int_n;
   logic        net_busy, stat_load, assoc_load;
   logic [7:0]  stat_bits;
   logic [15:0] assoc_data, cam_rdata;
   logic        hcam_go, hcam_busy, hcam_cmd, hcam_write, hcam_ec_low;
   logic [15:0] hcam_wdata, ctrl_q, learn_op, update_op, purge_op;
   logic        purge_go;
   logic [7:0]  purge_old_ts, new_ts;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hreg_cam_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .we_n(we_n),
      .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ready(ready),
      .int_n(int_n), .net_busy(net_busy), .stat_load(stat_load),
      .stat_bits(stat_bits), .assoc_load(assoc_load), .assoc_data(assoc_data),
      .cam_rdata(cam_rdata), .hcam_go(hcam_go), .hcam_busy(hcam_busy),
      .hcam_cmd(hcam_cmd), .hcam_write(hcam_write), .hcam_ec_low(hcam_ec_low),
      .hcam_wdata(hcam_wdata), .ctrl_q(ctrl_q), .learn_op(learn_op),
      .update_op(update_op), .purge_op(purge_op), .purge_go(purge_go),
      .purge_old_ts(purge_old_ts), .new_ts(new_ts)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic release_bus();
      cs_n = 1'b1;
      as_n = 1'b1;
      @(posedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] v);
      @(negedge clk);
      cs_n = 1'b0; as_n = 1'b0; we_n = 1'b0; addr = a; d_in = v;
      @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b0, "R3", "ready low after start", 32'(ready), 0);
      @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b1, "R3", "ready high after capture", 32'(ready), 1);
      release_bus();
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      cs_n = 1'b0; as_n = 1'b0; we_n = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b1, "R4", "ready stays high on read", 32'(ready), 1);
      @(posedge clk);
      @(negedge clk);
      chk(d_oe == 1'b1, "R4", "data driven", 32'(d_oe), 1);
      v = d_out;
      cs_n = 1'b1; as_n = 1'b1;
      #1;
      chk(d_oe == 1'b0, "R9", "bus released with select high", 32'(d_oe), 0);
      @(posedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk(ready && int_n && !d_oe, "R1", "idle outputs after reset",
          {29'd0, ready, int_n, d_oe}, 32'h6);
      bus_read(4'h0, v);  chk(v == 16'h0000, "R1", "control reset", v, 16'h0000);
      bus_read(4'h2, v);  chk(v == 16'h0334, "R1", "learn reset", v, 16'h0334);
      bus_read(4'h8, v);  chk(v == 16'h0300, "R1", "update reset", v, 16'h0300);
      bus_read(4'h9, v);  chk(v == 16'h043D, "R1", "purge opcode reset", v, 16'h043D);
      bus_read(4'hA, v);  chk(v == 16'h0000, "R1", "stamp reset", v, 16'h0000);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      bus_write(4'h0, 16'h2109);
      bus_write(4'h2, 16'hA55A);
      bus_write(4'h8, 16'h0328);
      bus_write(4'h9, 16'h1234);
      bus_read(4'h0, v); chk(v == 16'h2109, "R1", "control readback", v, 16'h2109);
      chk(ctrl_q == 16'h2109, "R3", "control captured", ctrl_q, 16'h2109);
      bus_read(4'h2, v); chk(v == 16'hA55A, "R1", "learn readback", v, 16'hA55A);
      bus_read(4'h8, v); chk(v == 16'h0328, "R1", "update readback", v, 16'h0328);
      bus_read(4'h9, v); chk(v == 16'h1234, "R1", "purge op readback", v, 16'h1234);
      bus_write(4'h1, 16'hFFFF);
      bus_read(4'h1, v); chk(v == 16'h0000, "R1", "status ignores write", v, 16'h0000);
      chk(int_n == 1'b1, "R1", "no interrupt from status write", 32'(int_n), 1);
      bus_write(4'h3, 16'hFFFF);
      bus_read(4'h3, v); chk(v == 16'h0000, "R1", "assoc ignores write", v, 16'h0000);
   endtask

   task automatic t_cam(input logic [3:0] a, input bit wr, input logic [15:0] v,
                        input int busy);
      int n;
      int lat;
      bit seen;
      n = 0; seen = 1'b0;
      lat = wr ? 3 : 5;
      @(negedge clk);
      net_busy = (busy > 0);
      cam_rdata = v ^ 16'h5555;
      cs_n = 1'b0; as_n = 1'b0; we_n = !wr; addr = a; d_in = v;
      @(posedge clk);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (hcam_go) begin
            seen = 1'b1;
            chk(i == busy, "R6", "grant at first idle edge", i, busy);
            chk(hcam_cmd == !a[1], "R5", "command/data select", 32'(hcam_cmd), 32'(!a[1]));
            chk(hcam_ec_low == !a[0], "R5", "chain enable level", 32'(hcam_ec_low), 32'(!a[0]));
            chk(hcam_write == wr, "R5", "direction", 32'(hcam_write), 32'(wr));
            if (wr) chk(hcam_wdata == v, "R5", "write data", hcam_wdata, v);
         end
         if (i == busy - 1) net_busy = 1'b0;
         if (ready) break;
         n++;
      end
      chk(seen, "R5", "grant issued", 32'(seen), 1);
      chk(n == busy + lat, "R6", "ready low span", n, busy + lat);
      if (!wr) begin
         chk(d_oe == 1'b1, "R5", "cam read driven", 32'(d_oe), 1);
         chk(d_out == (v ^ 16'h5555), "R5", "cam read data", d_out, v ^ 16'h5555);
      end
      release_bus();
   endtask

   task automatic pulse_status(input logic [7:0] b);
      @(negedge clk);
      stat_load = 1'b1; stat_bits = b;
      @(negedge clk);
      stat_load = 1'b0; stat_bits = 8'h00;
   endtask

   task automatic t_status();
      logic [15:0] v;
      pulse_status(8'h81);
      chk(int_n == 1'b0, "R7", "interrupt on result", 32'(int_n), 0);
      pulse_status(8'h02);
      bus_read(4'h1, v);
      chk(v == 16'h0083, "R7", "status accumulates", v, 16'h0083);
      chk(int_n == 1'b1, "R7", "interrupt cleared by read", 32'(int_n), 1);
      bus_read(4'h1, v);
      chk(v == 16'h0000, "R7", "status cleared", v, 16'h0000);
   endtask

   task automatic t_collide();
      logic [15:0] v;
      pulse_status(8'h01);
      @(negedge clk);
      cs_n = 1'b0; as_n = 1'b0; we_n = 1'b1; addr = 4'h1;
      @(posedge clk);
      @(negedge clk);
      stat_load = 1'b1; stat_bits = 8'h5A;
      @(posedge clk);
      @(negedge clk);
      stat_load = 1'b0; stat_bits = 8'h00;
      chk(d_out == 16'h0001, "R7", "collision read old value", d_out, 16'h0001);
      chk(int_n == 1'b0, "R7", "new result keeps interrupt", 32'(int_n), 0);
      release_bus();
      bus_read(4'h1, v);
      chk(v == 16'h005A, "R7", "new bits survive clear", v, 16'h005A);
      chk(int_n == 1'b1, "R7", "interrupt released", 32'(int_n), 1);
   endtask

   task automatic t_assoc();
      logic [15:0] v;
      @(negedge clk);
      assoc_load = 1'b1; assoc_data = 16'hBEEF;
      @(negedge clk);
      assoc_load = 1'b0; assoc_data = 16'h0000;
      bus_read(4'h3, v);
      chk(v == 16'hBEEF, "R10", "associated data", v, 16'hBEEF);
   endtask

   task automatic t_purge();
      @(negedge clk);
      cs_n = 1'b0; as_n = 1'b0; we_n = 1'b0; addr = 4'hA; d_in = 16'h7F12;
      @(posedge clk);
      @(negedge clk);
      chk(purge_go == 1'b0, "R8", "no pulse before capture", 32'(purge_go), 0);
      @(posedge clk);
      @(negedge clk);
      chk(purge_go == 1'b1, "R8", "purge pulse", 32'(purge_go), 1);
      chk(purge_old_ts == 8'h12, "R8", "old stamp", purge_old_ts, 8'h12);
      chk(new_ts == 8'h7F, "R8", "new stamp", new_ts, 8'h7F);
      release_bus();
      @(negedge clk);
      chk(purge_go == 1'b0, "R8", "pulse is single", 32'(purge_go), 0);
   endtask

   task automatic t_strobe();
      logic [15:0] v;
      @(negedge clk);
      as_n = 1'b0; we_n = 1'b0; addr = 4'h2; d_in = 16'h1357;
      @(negedge clk);
      chk(ready == 1'b1, "R2", "strobe alone starts nothing", 32'(ready), 1);
      addr = 4'h0;
      @(negedge clk);
      chk(ready == 1'b1, "R2", "still idle without select", 32'(ready), 1);
      cs_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b0, "R2", "access starts with both low", 32'(ready), 0);
      @(posedge clk);
      release_bus();
      bus_read(4'h2, v);
      chk(v == 16'h1357, "R2", "latched address used", v, 16'h1357);
      bus_read(4'h0, v);
      chk(v == 16'h2109, "R2", "later address ignored", v, 16'h2109);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; as_n = 1'b1; we_n = 1'b1; addr = '0; d_in = '0;
      net_busy = 1'b0; stat_load = 1'b0; stat_bits = '0; assoc_load = 1'b0;
      assoc_data = '0; cam_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(d_oe == 1'b0, "R9", "bus idle after reset", 32'(d_oe), 0);
      t_reset();
      t_regs();
      t_cam(4'h4, 1'b1, 16'h0228, 0);
      t_cam(4'h7, 1'b0, 16'h00F0, 0);
      t_cam(4'h5, 1'b1, 16'h0700, 4);
      t_cam(4'h6, 1'b0, 16'h3C3C, 3);
      t_status();
      t_collide();
      t_assoc();
      t_purge();
      t_strobe();
      @(negedge clk);
      cs_n = 1'b0; we_n = 1'b1;
      #1;
      chk(d_oe == 1'b0, "R9", "no drive without a read", 32'(d_oe), 0);
      cs_n = 1'b1;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule